// File: doc/BRIEF.md
# I2C Supervisor Register Interface

This block is a 7-bit-address I2C target that gives a host controller access to a power supervisor's state. It samples SCL and SDA on the system clock and drives SDA low through an open-drain enable. Over the bus the host can read live monitor-comparator and output-drive status, start an analog conversion and poll for its completion, read the result as two bytes, set two bytes of general-purpose outputs, and trigger a device-wide reset by writing to a dedicated register. An active-low, open-drain alert line tells the host that the monitor status has changed. Once the host releases it, the line stays quiet until the host re-arms it.

A write transfer sets an 8-bit register pointer from its first data byte. Every later data byte in the same transfer is written to that same register. A read, usually placed after a repeated START that follows a pointer write, returns the register at the pointer. The pointer does not advance, so a multi-byte read returns the same register again. The conversion command leaves on a valid/ready channel: `adc_cmd_valid_o` rises when the host writes the command register, and it holds with a stable channel until `adc_cmd_ready_i` is seen. The result channel has no back-pressure. The block captures `adc_res_data_i` on any cycle in which `adc_res_valid_i` is high.

Register map used below: 0x00/0x01 monitor status low/high byte, 0x02/0x03 output status low/high byte, 0x06 conversion control (write: bits [3:0] channel; read: bit 7 DONE, bits [3:0] channel), 0x07/0x08 result low/high byte, 0x0E/0x0F general-purpose output low/high byte, 0x10 alert control (bit 0 = alert disable), 0x12 reset trigger.

Top module: `sup_i2c_regif`

## Requirements
- R1: The block ACKs an address byte whose upper seven bits equal `dev_addr_i` and NACKs any other address. A transfer to another address changes no register.
- R2: In a write transfer, the first data byte loads the register pointer. Every further data byte is written to the register at that pointer. When two bytes follow the pointer, the last one remains.
- R3: In a read transfer, the block drives the pointed-to register onto SDA, MSB first. SDA drive changes only while SCL is low. A master ACK gives another copy of the same register, and a master NACK ends driving.
- R4: Registers 0x0E and 0x0F are read/write and appear on `gp_out_o[7:0]` and `gp_out_o[15:8]`. They reset to zero.
- R5: Registers 0x00/0x01 return `mon_status_i` and registers 0x02/0x03 return `out_status_i` (low byte first address), both zero-extended and sampled at read time.
- R6: An address outside the map reads as 0x00, and a write to it changes no mapped register.
- R7: Writing 0x06 while no command is pending raises `adc_cmd_valid_o` with `adc_cmd_chan_o` = data[3:0], held stable until `adc_cmd_ready_i`. The write also clears DONE (0x06 bit 7). DONE sets when `adc_res_valid_i` is seen.
- R8: Register 0x07 returns result bits [7:0] and 0x08 returns the upper result bits, zero-extended.
- R9: Writing any value to 0x12 gives a one-cycle `dev_rst_o` pulse. On the next cycle the general-purpose outputs, alert control, alert line, pending command, DONE and result are back at zero.
- R10: While 0x10 bit 0 is 0, a change of `mon_status_i` latches `alert_pull_o` high. Writing bit 0 = 1 releases it, and further changes are then ignored. Writing bit 0 = 0 re-arms the alert without asserting it.
- R11: A STOP in the middle of a byte abandons the byte without writing anything. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_addr_i | input | 7 | Programmable target address |
| mon_status_i | input | MON_W | Monitor comparator status |
| out_status_i | input | OUT_W | Logic values driving the output pins |
| adc_cmd_valid_o | output | 1 | Conversion request valid |
| adc_cmd_ready_i | input | 1 | Converter accepts request |
| adc_cmd_chan_o | output | CHAN_W | Channel to convert |
| adc_res_valid_i | input | 1 | Conversion result valid |
| adc_res_data_i | input | ADC_W | Conversion result |
| gp_out_o | output | 16 | General-purpose output register bits |
| dev_rst_o | output | 1 | One-cycle device reset pulse |
| alert_pull_o | output | 1 | 1 pulls the alert line low |

## Verification
The bench acts as a bit-banged bus master. It runs single-byte writes, writes with two data bytes after the pointer, pointer-then-repeated-START reads, and two-byte reads with ACK then NACK. Comparing these tells apart a pointer that stays put from one that auto-increments, and a commit on the last byte from a commit on the first. A wrong address, unmapped registers and a STOP inside a data byte show whether stray traffic can disturb state. The conversion is exercised with a fast converter and with a slow one, which shows whether DONE is cleared at the command or only at the result. The alert is exercised through its arm, release, ignore and re-arm stages.

// File: rtl/sup_i2c_pkg.sv
package sup_i2c_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_ADDR, BUS_AACK, BUS_WDATA, BUS_WACK, BUS_RDATA, BUS_RACK
  } bus_state_e;

  localparam logic [7:0] REG_MON_LO  = 8'h00;
  localparam logic [7:0] REG_MON_HI  = 8'h01;
  localparam logic [7:0] REG_OUT_LO  = 8'h02;
  localparam logic [7:0] REG_OUT_HI  = 8'h03;
  localparam logic [7:0] REG_ADC_CTL = 8'h06;
  localparam logic [7:0] REG_ADC_LO  = 8'h07;
  localparam logic [7:0] REG_ADC_HI  = 8'h08;
  localparam logic [7:0] REG_GP_LO   = 8'h0E;
  localparam logic [7:0] REG_GP_HI   = 8'h0F;
  localparam logic [7:0] REG_ALERT   = 8'h10;
  localparam logic [7:0] REG_RESET   = 8'h12;
endpackage

// File: rtl/sup_i2c_sync.sv
module sup_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sup_i2c_bus.sv
module sup_i2c_bus
  import sup_i2c_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl,
  input  logic        sda,
  input  logic [6:0]  dev_addr,
  input  logic [7:0]  rd_data,
  output logic        sda_pull,
  output logic        wr_stb,
  output logic [7:0]  wr_addr,
  output logic [7:0]  wr_data
);
  bus_state_e state;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx, ptr;
  logic       rw, first, mnack;

  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire byte_end = (bitcnt == 4'd8);

  assign wr_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BUS_IDLE; scl_d <= 1'b1; sda_d <= 1'b1;
      bitcnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; mnack <= 1'b0;
      sda_pull <= 1'b0; wr_stb <= 1'b0; wr_data <= '0;
    end else begin
      scl_d  <= scl;
      sda_d  <= sda;
      wr_stb <= 1'b0;
      if (start_c) begin
        state <= BUS_ADDR; bitcnt <= '0; first <= 1'b1; sda_pull <= 1'b0;
      end else if (stop_c) begin
        state <= BUS_IDLE; sda_pull <= 1'b0;
      end else begin
        case (state)
          BUS_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && byte_end) begin
              if (sh[7:1] == dev_addr) begin
                sda_pull <= 1'b1; rw <= sh[0]; state <= BUS_AACK;
              end else begin
                state <= BUS_IDLE;
              end
            end
          end
          BUS_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              tx <= rd_data; sda_pull <= ~rd_data[7]; state <= BUS_RDATA;
            end else begin
              sda_pull <= 1'b0; state <= BUS_WDATA;
            end
          end
          BUS_WDATA: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && byte_end) begin
              sda_pull <= 1'b1; state <= BUS_WACK;
              if (first) begin
                ptr <= sh; first <= 1'b0;
              end else begin
                wr_stb <= 1'b1; wr_data <= sh;
              end
            end
          end
          BUS_WACK: if (scl_fall) begin
            sda_pull <= 1'b0; bitcnt <= '0; state <= BUS_WDATA;
          end
          BUS_RDATA: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            else if (scl_fall) begin
              if (byte_end) begin
                sda_pull <= 1'b0; state <= BUS_RACK;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_pull <= ~tx[6];
              end
            end
          end
          BUS_RACK: begin
            if (scl_rise) mnack <= sda;
            else if (scl_fall) begin
              if (mnack) state <= BUS_IDLE;
              else begin
                tx <= rd_data; sda_pull <= ~rd_data[7];
                bitcnt <= '0; state <= BUS_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sup_i2c_regs.sv
module sup_i2c_regs
  import sup_i2c_pkg::*;
#(
  parameter int MON_W  = 16,
  parameter int OUT_W  = 16,
  parameter int ADC_W  = 10,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [MON_W-1:0]  mon_status,
  input  logic [OUT_W-1:0]  out_status,
  output logic              adc_cmd_valid,
  input  logic              adc_cmd_ready,
  output logic [CHAN_W-1:0] adc_cmd_chan,
  input  logic              adc_res_valid,
  input  logic [ADC_W-1:0]  adc_res_data,
  output logic [15:0]       gp_out,
  output logic              dev_rst,
  output logic              alert_pull
);
  logic             alert_dis, done, prev_ok;
  logic [ADC_W-1:0] result;
  logic [MON_W-1:0] mon_prev;

  wire alert_evt = prev_ok && (mon_prev != mon_status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_out <= '0; alert_dis <= 1'b0; adc_cmd_valid <= 1'b0; adc_cmd_chan <= '0;
      done <= 1'b0; result <= '0; alert_pull <= 1'b0; dev_rst <= 1'b0;
      mon_prev <= '0; prev_ok <= 1'b0;
    end else begin
      dev_rst  <= wr_stb && (addr == REG_RESET);
      mon_prev <= mon_status;
      prev_ok  <= 1'b1;
      if (dev_rst) begin
        gp_out <= '0; alert_dis <= 1'b0; adc_cmd_valid <= 1'b0; adc_cmd_chan <= '0;
        done <= 1'b0; result <= '0; alert_pull <= 1'b0;
      end else begin
        if (adc_cmd_valid && adc_cmd_ready) adc_cmd_valid <= 1'b0;
        if (adc_res_valid) begin
          result <= adc_res_data; done <= 1'b1;
        end
        if (alert_evt && !alert_dis) alert_pull <= 1'b1;
        if (wr_stb) begin
          case (addr)
            REG_GP_LO: gp_out[7:0]  <= wr_data;
            REG_GP_HI: gp_out[15:8] <= wr_data;
            REG_ADC_CTL: if (!adc_cmd_valid) begin
              adc_cmd_valid <= 1'b1; adc_cmd_chan <= wr_data[CHAN_W-1:0]; done <= 1'b0;
            end
            REG_ALERT: begin
              alert_dis <= wr_data[0];
              if (wr_data[0]) alert_pull <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic [15:0] mon16, out16, res16;
  logic [3:0]  chan4;
  assign mon16 = 16'(mon_status);
  assign out16 = 16'(out_status);
  assign res16 = 16'(result);
  assign chan4 = 4'(adc_cmd_chan);

  always_comb begin
    case (addr)
      REG_MON_LO:  rd_data = mon16[7:0];
      REG_MON_HI:  rd_data = mon16[15:8];
      REG_OUT_LO:  rd_data = out16[7:0];
      REG_OUT_HI:  rd_data = out16[15:8];
      REG_ADC_CTL: rd_data = {done, 3'b000, chan4};
      REG_ADC_LO:  rd_data = res16[7:0];
      REG_ADC_HI:  rd_data = res16[15:8];
      REG_GP_LO:   rd_data = gp_out[7:0];
      REG_GP_HI:   rd_data = gp_out[15:8];
      REG_ALERT:   rd_data = {7'b0, alert_dis};
      default:     rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/sup_i2c_regif.sv
module sup_i2c_regif #(
  parameter int MON_W       = 16,
  parameter int OUT_W       = 16,
  parameter int ADC_W       = 10,
  parameter int CHAN_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [6:0]        dev_addr_i,
  input  logic [MON_W-1:0]  mon_status_i,
  input  logic [OUT_W-1:0]  out_status_i,
  output logic              adc_cmd_valid_o,
  input  logic              adc_cmd_ready_i,
  output logic [CHAN_W-1:0] adc_cmd_chan_o,
  input  logic              adc_res_valid_i,
  input  logic [ADC_W-1:0]  adc_res_data_i,
  output logic [15:0]       gp_out_o,
  output logic              dev_rst_o,
  output logic              alert_pull_o
);
  logic       scl_s, sda_s, wr_stb;
  logic [7:0] wr_addr, wr_data, rd_data;

  sup_i2c_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  sup_i2c_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  sup_i2c_bus bus_i (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s), .dev_addr(dev_addr_i),
    .rd_data(rd_data), .sda_pull(sda_pull_o), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sup_i2c_regs #(.MON_W(MON_W), .OUT_W(OUT_W), .ADC_W(ADC_W), .CHAN_W(CHAN_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .mon_status(mon_status_i), .out_status(out_status_i),
    .adc_cmd_valid(adc_cmd_valid_o), .adc_cmd_ready(adc_cmd_ready_i),
    .adc_cmd_chan(adc_cmd_chan_o), .adc_res_valid(adc_res_valid_i),
    .adc_res_data(adc_res_data_i), .gp_out(gp_out_o), .dev_rst(dev_rst_o),
    .alert_pull(alert_pull_o)
  );
endmodule

// File: rtl/sup_i2c_regif_chk.sv
module sup_i2c_regif_chk #(
  parameter int MON_W  = 16,
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [MON_W-1:0]  mon_status_i,
  input logic              adc_cmd_valid_o,
  input logic              adc_cmd_ready_i,
  input logic [CHAN_W-1:0] adc_cmd_chan_o,
  input logic [15:0]       gp_out_o,
  input logic              dev_rst_o,
  input logic              alert_pull_o
);
  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R7
  adc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cmd_valid_o && !adc_cmd_ready_i && !dev_rst_o |=> adc_cmd_valid_o && $stable(adc_cmd_chan_o));

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |=> !dev_rst_o);

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |=> (gp_out_o == 16'h0) && !alert_pull_o && !adc_cmd_valid_o);

  // R10
  alert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_pull_o) |-> $past(mon_status_i) != $past(mon_status_i, 2));
endmodule

bind sup_i2c_regif sup_i2c_regif_chk #(.MON_W(MON_W), .CHAN_W(CHAN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .mon_status_i(mon_status_i), .adc_cmd_valid_o(adc_cmd_valid_o),
  .adc_cmd_ready_i(adc_cmd_ready_i), .adc_cmd_chan_o(adc_cmd_chan_o),
  .gp_out_o(gp_out_o), .dev_rst_o(dev_rst_o), .alert_pull_o(alert_pull_o)
);

// File: tb/sup_i2c_regif_tb_top.sv
`timescale 1ns/1ps
module sup_i2c_regif_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m_low = 1'b0;
  logic sda_pull, sda_line;
  logic [15:0] mon = 16'h1234, outs = 16'hA50F, gp;
  logic cmd_v, cmd_r = 1'b0, res_v = 1'b0, dev_rst, alert;
  logic [3:0] cmd_ch;
  logic [9:0] res_d = '0;

  assign sda_line = ~(sda_m_low | sda_pull);

  sup_i2c_regif dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .dev_addr_i(DEV), .mon_status_i(mon), .out_status_i(outs),
    .adc_cmd_valid_o(cmd_v), .adc_cmd_ready_i(cmd_r), .adc_cmd_chan_o(cmd_ch),
    .adc_res_valid_i(res_v), .adc_res_data_i(res_d), .gp_out_o(gp),
    .dev_rst_o(dev_rst), .alert_pull_o(alert)
  );

  int checks = 0, errors = 0;
  int rst_cnt = 0, cmd_cnt = 0, res_delay = 20;
  logic [3:0] last_ch = '0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  function automatic logic [9:0] conv_of(input logic [3:0] ch);
    return 10'h2C0 | 10'(ch);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(a == e, t, 32'(a), 32'(e));
    end
  end

  always @(negedge clk) if (dev_rst) rst_cnt++;

  // converter model
  initial forever begin
    @(negedge clk);
    if (rst_n && cmd_v && !cmd_r) begin
      logic [3:0] ch;
      repeat (3) @(negedge clk);
      ch = cmd_ch; cmd_r = 1'b1;
      @(negedge clk); cmd_r = 1'b0;
      cmd_cnt++; last_ch = ch;
      repeat (res_delay) @(negedge clk);
      res_d = conv_of(ch); res_v = 1'b1;
      @(negedge clk); res_v = 1'b0;
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic i2c_start(); sda_m_low = 0; w(Q); scl_m = 1; w(Q); sda_m_low = 1; w(Q); scl_m = 0; w(Q); endtask
  task automatic i2c_stop(); sda_m_low = 1; w(Q); scl_m = 1; w(Q); sda_m_low = 0; w(Q); endtask
  task automatic send_bit(input logic b); sda_m_low = !b; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q); endtask
  task automatic recv_bit(output logic b); sda_m_low = 0; w(Q); scl_m = 1; w(Q); b = sda_line; w(Q); scl_m = 0; w(Q); endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a); ack = !a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) begin
      logic b; recv_bit(b); d[i] = b;
    end
    send_bit(last);
  endtask

  task automatic reg_write(input logic [7:0] ra, input logic [7:0] d);
    bit ack;
    i2c_start(); wr_byte({DEV, 1'b0}, ack);
    chk(ack, "R1 address ack", 32'(ack), 1);
    wr_byte(ra, ack); wr_byte(d, ack); i2c_stop(); w(4);
  endtask

  task automatic reg_read(input logic [7:0] ra, input logic [7:0] e, input string tag);
    bit ack; logic [7:0] d;
    exp_q.push_back(e); tag_q.push_back(tag);
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(ra, ack);
    i2c_start(); wr_byte({DEV, 1'b1}, ack);
    rd_byte(d, 1'b1); i2c_stop();
    act_q.push_back(d); w(4);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d0, d1;
    w(10); rst_n = 1'b1; w(5);
    // R4 R10 reset state
    chk(gp == 16'h0, "R4 reset gp_out", 32'(gp), 0);
    chk(!alert && !sda_pull && !cmd_v, "R10 reset alert/sda/cmd", {alert, sda_pull, cmd_v}, 0);

    // R5 status readback
    reg_read(8'h00, 8'h34, "R5 mon lo");
    reg_read(8'h01, 8'h12, "R5 mon hi");
    reg_read(8'h02, 8'h0F, "R5 out lo");
    reg_read(8'h03, 8'hA5, "R5 out hi");

    // R4 GP registers
    reg_write(8'h0E, 8'h5A); reg_write(8'h0F, 8'hC3);
    chk(gp == 16'hC35A, "R4 gp_out pins", 32'(gp), 32'hC35A);
    reg_read(8'h0E, 8'h5A, "R4 gp lo readback");
    reg_read(8'h0F, 8'hC3, "R4 gp hi readback");

    // R2 pointer fixed, two data bytes
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'h0E, ack);
    wr_byte(8'h11, ack); chk(ack, "R2 data ack", 32'(ack), 1);
    wr_byte(8'h22, ack); i2c_stop(); w(4);
    chk(gp == 16'hC322, "R2 last byte same register", 32'(gp), 32'hC322);

    // R1 wrong address
    i2c_start(); wr_byte({7'h3B, 1'b0}, ack);
    chk(!ack, "R1 mismatch nack", 32'(ack), 0);
    wr_byte(8'h0E, ack); wr_byte(8'h99, ack); i2c_stop(); w(4);
    chk(gp == 16'hC322, "R1 mismatch no write", 32'(gp), 32'hC322);

    // R6 unmapped
    reg_write(8'h20, 8'h77); reg_write(8'h05, 8'h66);
    reg_read(8'h20, 8'h00, "R6 unmapped read");
    reg_read(8'h05, 8'h00, "R6 unmapped 0x05 read");
    chk(gp == 16'hC322, "R6 unmapped write ignored", 32'(gp), 32'hC322);

    // R3 two-byte read, same register
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'h0F, ack);
    i2c_start(); wr_byte({DEV, 1'b1}, ack);
    rd_byte(d0, 1'b0); rd_byte(d1, 1'b1); i2c_stop(); w(4);
    chk(d0 == 8'hC3, "R3 first byte", 32'(d0), 32'hC3);
    chk(d1 == 8'hC3, "R3 repeat byte", 32'(d1), 32'hC3);
    chk(!sda_pull, "R3 released after nack", 32'(sda_pull), 0);

    // R7 R8 conversion, fast converter
    reg_read(8'h06, 8'h00, "R7 done clear before cmd");
    reg_write(8'h06, 8'h05); w(60);
    chk(cmd_cnt == 1 && last_ch == 4'h5, "R7 command channel", {cmd_cnt[15:0], 12'h0, last_ch}, 32'h0001_0005);
    reg_read(8'h06, 8'h85, "R7 done set");
    reg_read(8'h07, 8'hC5, "R8 result lo");
    reg_read(8'h08, 8'h02, "R8 result hi");

    // R7 slow converter: DONE cleared by command
    res_delay = 3000;
    reg_write(8'h06, 8'h03);
    reg_read(8'h06, 8'h03, "R7 done cleared by command");
    w(3200);
    reg_read(8'h06, 8'h83, "R7 done after slow result");
    reg_read(8'h07, 8'hC3, "R8 slow result lo");
    res_delay = 20;

    // R10 alert sequence
    mon = 16'h1235; w(6);
    chk(alert, "R10 alert on change", 32'(alert), 1);
    mon = 16'h1236; w(6);
    chk(alert, "R10 alert latched", 32'(alert), 1);
    reg_write(8'h10, 8'h01);
    chk(!alert, "R10 release", 32'(alert), 0);
    mon = 16'h1237; w(6);
    chk(!alert, "R10 ignored while disabled", 32'(alert), 0);
    reg_read(8'h10, 8'h01, "R10 disable bit readback");
    reg_write(8'h10, 8'h00);
    chk(!alert, "R10 rearm no assert", 32'(alert), 0);
    mon = 16'h1238; w(6);
    chk(alert, "R10 rearmed alert", 32'(alert), 1);

    // R9 reset register
    reg_write(8'h12, 8'hAB);
    chk(rst_cnt == 1, "R9 one reset pulse", 32'(rst_cnt), 1);
    chk(gp == 16'h0 && !alert, "R9 state cleared", {gp, 15'h0, alert}, 0);
    reg_read(8'h06, 8'h00, "R9 done cleared");
    reg_read(8'h07, 8'h00, "R9 result cleared");

    // R11 stop inside byte
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'h0E, ack);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    i2c_stop(); w(4);
    chk(gp == 16'h0, "R11 aborted byte not written", 32'(gp), 0);
    reg_write(8'h0E, 8'h3C);
    chk(gp == 16'h003C, "R11 bus usable after abort", 32'(gp), 32'h3C);

    w(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule